// File: doc/BRIEF.md
# Keyframe Animation Frame Sequencer

This block plays short LED animations from a small on-chip store of eight keyframes. Each keyframe is an 18-byte record: two bytes of per-channel enable bits followed by sixteen duty-cycle bytes. The record store and four control registers are written through a simple byte-wide register write port. The block drives the selected keyframe's 16 enable bits and 16 duty bytes to a downstream PWM bank.

Two playback modes exist. In timed playback the block starts at a programmed keyframe and advances one keyframe per programmed delay, a power of two of an external base-tick strobe, wrapping from the last keyframe back to the first. In level-follow mode an externally supplied 8-bit magnitude is sampled once every N pulses of an external sample-clock strobe, and its three most significant bits pick the keyframe. The outputs are registered and reload only when the shown keyframe changes.

Top module: `kfs_frame_seq`

## Requirements
- R1: After reset `led_en_o` and `duty_o` are all zero.
- R2: The mode register (address 01h, bits [1:0]) selects 00 direct, 01 timed playback, 10 level-follow, 11 reserved; in 00 and 11 the outputs hold their value whatever `base_tick_i`, `rate_tick_i` and `level_i` do.
- R3: In timed playback the keyframe advances on exactly the 2^code-th `base_tick_i` pulse after the previous advance or after entry, where code is bits [7:5] of the delay register (address 02h).
- R4: A write of 01 to the mode register while the mode is not 01 loads the start keyframe (bits [7:5] of address 03h, 000 = first keyframe) at that write's clock edge and restarts the delay count; a write of 01 while already in mode 01 changes neither the keyframe nor the count.
- R5: Timed playback steps the keyframe index up by one and wraps from the eighth keyframe (index 7) to the first (index 0), not to the start keyframe.
- R6: In level-follow mode a sample is taken on every N-th `rate_tick_i` pulse, N being the value at address 04h, and the keyframe index becomes `level_i[7:5]` (level 0 gives the first keyframe, 255 the eighth).
- R7: In level-follow mode with N = 0 no sample is taken and the keyframe is held.
- R8: Keyframe k (0..7) occupies bytes 20h+18k to 20h+18k+17; record byte 0 drives `led_en_o[15:8]`, byte 1 drives `led_en_o[7:0]`, and byte 2+j drives the duty of channel 15-j (`duty_o[(15-j)*8 +: 8]`); writes outside 20h..AFh and outside the four control addresses change nothing.
- R9: The outputs reload only when the keyframe index changes or timed playback is entered; a write to the record currently shown does not reach the outputs until that keyframe is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte address |
| wr_data_i | input | 8 | Register write data |
| base_tick_i | input | 1 | Delay time-base strobe, one pulse per delay unit |
| rate_tick_i | input | 1 | Sample-clock strobe for level-follow mode |
| level_i | input | 8 | Signal magnitude for level-follow mode |
| led_en_o | output | 16 | Per-channel enable bits of the shown keyframe |
| duty_o | output | 128 | Duty bytes of the shown keyframe, channel c at bits [8c+7:8c] |

## Verification
The hardest situation to reach is the longest delay code, where the advance must land on exactly the 128th base tick and not one earlier, together with the case where a repeated write of timed mode arrives half-way through a count and must not restart it. The bench drives these as directed sequences with a tick-by-tick check before and at the boundary. The stale-output rule is reached by rewriting the record currently on display and then moving to another keyframe and back, while level-follow is covered with random magnitudes and random divider values from a fixed seed.

// File: rtl/kfs_pkg.sv
package kfs_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_AUTO   = 2'b01,
        MODE_LEVEL  = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    localparam int REG_MODE  = 'h01;
    localparam int REG_DELAY = 'h02;
    localparam int REG_START = 'h03;
    localparam int REG_RATE  = 'h04;

endpackage

// File: rtl/kfs_frame_mem.sv
module kfs_frame_mem #(
    parameter int NUM_FRAMES = 8,
    parameter int REC_BYTES  = 18,
    parameter int ADDR_W     = 8,
    parameter int FRAME_BASE = 'h20,
    localparam int FI_W      = $clog2(NUM_FRAMES),
    localparam int MEM_BYTES = NUM_FRAMES * REC_BYTES,
    localparam int MEM_IW    = $clog2(MEM_BYTES)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [FI_W-1:0]        rd_frame_i,
    output logic [REC_BYTES*8-1:0] rec_o
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(FRAME_BASE);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(FRAME_BASE + MEM_BYTES);

    logic [7:0]        mem_q [MEM_BYTES];
    logic              hit;
    logic [ADDR_W-1:0] off;

    assign hit = wr_en_i && (wr_addr_i >= LO_ADDR) && (wr_addr_i < HI_ADDR);
    assign off = wr_addr_i - LO_ADDR;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else if (hit) begin
            mem_q[MEM_IW'(off)] <= wr_data_i;
        end
    end

    always_comb begin
        for (int j = 0; j < REC_BYTES; j++) begin
            rec_o[j*8 +: 8] = mem_q[MEM_IW'(int'(rd_frame_i) * REC_BYTES + j)];
        end
    end

endmodule

// File: rtl/kfs_rate_div.sv
module kfs_rate_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              rate_tick_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              sample_o
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } div_state_t;

    div_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        sample_o = 1'b0;
        if (!en_i) begin
            s_d.cnt = '0;
        end else if (rate_tick_i && (rate_i != '0)) begin
            if (({1'b0, s_q.cnt} + 1'b1) >= {1'b0, rate_i}) begin
                s_d.cnt  = '0;
                sample_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/kfs_play_ctrl.sv
module kfs_play_ctrl
    import kfs_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int DELAY_W    = 3,
    localparam int FI_W      = $clog2(NUM_FRAMES),
    localparam int CNT_W     = 1 << DELAY_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  mode_e              mode_i,
    input  logic               enter_auto_i,
    input  logic [FI_W-1:0]    start_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic               base_tick_i,
    input  logic               sample_i,
    input  logic [FI_W-1:0]    level_idx_i,
    output logic [FI_W-1:0]    frame_d_o,
    output logic [FI_W-1:0]    frame_q_o,
    output logic               load_o
);

    localparam logic [FI_W-1:0] LAST = FI_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W:0]  ONE  = 1;

    typedef struct packed {
        logic [FI_W-1:0]  frame;
        logic [CNT_W-1:0] cnt;
    } play_state_t;

    play_state_t    s_d, s_q;
    logic [CNT_W:0] target;

    assign target = ONE << delay_i;

    always_comb begin
        s_d    = s_q;
        load_o = 1'b0;
        if (enter_auto_i) begin
            s_d.frame = start_i;
            s_d.cnt   = '0;
            load_o    = 1'b1;
        end else begin
            unique case (mode_i)
                MODE_AUTO: begin
                    if (base_tick_i) begin
                        if (({1'b0, s_q.cnt} + 1'b1) == target) begin
                            s_d.cnt   = '0;
                            s_d.frame = (s_q.frame == LAST) ? '0 : s_q.frame + 1'b1;
                            load_o    = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                MODE_LEVEL: begin
                    if (sample_i && (level_idx_i != s_q.frame)) begin
                        s_d.frame = level_idx_i;
                        load_o    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign frame_d_o = s_d.frame;
    assign frame_q_o = s_q.frame;

endmodule

// File: rtl/kfs_frame_seq.sv
module kfs_frame_seq
    import kfs_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int NUM_CH     = 16,
    parameter int DELAY_W    = 3,
    parameter int RATE_W     = 8,
    parameter int LVL_W      = 8,
    parameter int ADDR_W     = 8,
    parameter int FRAME_BASE = 'h20
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [7:0]          wr_data_i,
    input  logic                base_tick_i,
    input  logic                rate_tick_i,
    input  logic [LVL_W-1:0]    level_i,
    output logic [NUM_CH-1:0]   led_en_o,
    output logic [NUM_CH*8-1:0] duty_o
);

    localparam int FI_W      = $clog2(NUM_FRAMES);
    localparam int EN_BYTES  = NUM_CH / 8;
    localparam int REC_BYTES = EN_BYTES + NUM_CH;

    typedef struct packed {
        mode_e              mode;
        logic [DELAY_W-1:0] delay;
        logic [FI_W-1:0]    start;
        logic [RATE_W-1:0]  rate;
        logic [NUM_CH-1:0]  led;
        logic [NUM_CH*8-1:0] duty;
    } top_state_t;

    top_state_t             s_d, s_q;
    logic                   enter_auto;
    logic                   sample;
    logic                   load;
    logic [FI_W-1:0]        frame_d;
    logic [FI_W-1:0]        frame_q;
    logic [FI_W-1:0]        level_idx;
    logic [REC_BYTES*8-1:0] rec;

    assign enter_auto = wr_en_i && (wr_addr_i == ADDR_W'(REG_MODE))
                        && (wr_data_i[1:0] == MODE_AUTO) && (s_q.mode != MODE_AUTO);
    assign level_idx  = FI_W'(level_i >> (LVL_W - FI_W));

    kfs_frame_mem #(
        .NUM_FRAMES (NUM_FRAMES),
        .REC_BYTES  (REC_BYTES),
        .ADDR_W     (ADDR_W),
        .FRAME_BASE (FRAME_BASE)
    ) u_mem (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_frame_i (frame_d),
        .rec_o      (rec)
    );

    kfs_rate_div #(
        .RATE_W (RATE_W)
    ) u_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (s_q.mode == MODE_LEVEL),
        .rate_tick_i (rate_tick_i),
        .rate_i      (s_q.rate),
        .sample_o    (sample)
    );

    kfs_play_ctrl #(
        .NUM_FRAMES (NUM_FRAMES),
        .DELAY_W    (DELAY_W)
    ) u_play (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mode_i       (s_q.mode),
        .enter_auto_i (enter_auto),
        .start_i      (s_q.start),
        .delay_i      (s_q.delay),
        .base_tick_i  (base_tick_i),
        .sample_i     (sample),
        .level_idx_i  (level_idx),
        .frame_d_o    (frame_d),
        .frame_q_o    (frame_q),
        .load_o       (load)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(REG_MODE))  s_d.mode  = mode_e'(wr_data_i[1:0]);
            if (wr_addr_i == ADDR_W'(REG_DELAY)) s_d.delay = DELAY_W'(wr_data_i >> (8 - DELAY_W));
            if (wr_addr_i == ADDR_W'(REG_START)) s_d.start = FI_W'(wr_data_i >> (8 - FI_W));
            if (wr_addr_i == ADDR_W'(REG_RATE))  s_d.rate  = RATE_W'(wr_data_i);
        end
        if (load) begin
            for (int i = 0; i < EN_BYTES; i++) begin
                s_d.led[(EN_BYTES-1-i)*8 +: 8] = rec[i*8 +: 8];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                s_d.duty[c*8 +: 8] = rec[(EN_BYTES + NUM_CH - 1 - c)*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign led_en_o = s_q.led;
    assign duty_o   = s_q.duty;

endmodule

// File: rtl/kfs_frame_seq_chk.sv
module kfs_frame_seq_chk #(
    parameter int NUM_FRAMES = 8,
    parameter int NUM_CH     = 16,
    parameter int RATE_W     = 8,
    localparam int FI_W      = $clog2(NUM_FRAMES)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [1:0]          mode_i,
    input logic                enter_i,
    input logic [FI_W-1:0]     start_i,
    input logic [FI_W-1:0]     frame_i,
    input logic [RATE_W-1:0]   rate_i,
    input logic [NUM_CH-1:0]   led_i,
    input logic [NUM_CH*8-1:0] duty_i
);

    localparam logic [FI_W-1:0] LAST = FI_W'(NUM_FRAMES - 1);

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_i == 2'b00 || mode_i == 2'b11) && !$past(enter_i))
        |-> ($stable(led_i) && $stable(duty_i))) // R2
        else $error("idle mode changed outputs");

    AST_ENTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_i |=> (frame_i == $past(start_i))) // R4
        else $error("entry did not load start frame");

    AST_AUTO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_i == 2'b01) && !$past(enter_i) && (frame_i != $past(frame_i)))
        |-> (frame_i == (($past(frame_i) == LAST) ? '0 : FI_W'($past(frame_i) + 1'b1)))) // R5
        else $error("timed playback skipped or wrapped wrongly");

    AST_ZERO_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_i == 2'b10 && rate_i == '0 && !enter_i) |-> $stable(frame_i)) // R7
        else $error("zero divider changed frame");

    AST_RELOAD_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(frame_i) && !$past(enter_i)) |-> ($stable(led_i) && $stable(duty_i))) // R9
        else $error("outputs reloaded without frame change");

endmodule

bind kfs_frame_seq kfs_frame_seq_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .NUM_CH     (NUM_CH),
    .RATE_W     (RATE_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (s_q.mode),
    .enter_i (enter_auto),
    .start_i (s_q.start),
    .frame_i (frame_q),
    .rate_i  (s_q.rate),
    .led_i   (led_en_o),
    .duty_i  (duty_o)
);

// File: tb/kfs_frame_seq_tb_top.sv
module kfs_frame_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         base_tick = 1'b0;
    logic         rate_tick = 1'b0;
    logic [7:0]   level = '0;
    logic [15:0]  led_en;
    logic [127:0] duty;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic [7:0] mem_m [144];

    always #(CLK_PERIOD/2) clk = ~clk;

    kfs_frame_seq dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .base_tick_i (base_tick),
        .rate_tick_i (rate_tick),
        .level_i     (level),
        .led_en_o    (led_en),
        .duty_o      (duty)
    );

    function automatic logic [15:0] exp_led(int f);
        return {mem_m[f*18], mem_m[f*18+1]};
    endfunction

    function automatic logic [127:0] exp_duty(int f);
        logic [127:0] d;
        for (int c = 0; c < 16; c++) d[c*8 +: 8] = mem_m[f*18 + 2 + (15 - c)];
        return d;
    endfunction

    task automatic check_vals(string req, logic [15:0] el, logic [127:0] ed);
        checks++;
        if (led_en !== el || duty !== ed) begin
            fails++;
            $display("FAIL %s: led=%h duty=%h expected led=%h duty=%h", req, led_en, duty, el, ed);
        end
    endtask

    task automatic check_frame(string req, int f);
        check_vals(req, exp_led(f), exp_duty(f));
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic btick();
        base_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic rtick();
        rate_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        rate_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int exp_f;
        logic [15:0]  held_l;
        logic [127:0] held_d;
        logic [7:0]   old_b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_vals("R1", '0, '0);

        // R8: fill record store
        for (int i = 0; i < 144; i++) begin
            mem_m[i] = 8'($urandom);
            wr(8'(8'h20 + i), mem_m[i]);
        end
        // R8: out-of-window writes ignored (model unchanged)
        wr(8'h1F, 8'hA5);
        wr(8'hB0, 8'h5A);
        wr(8'hFF, 8'h3C);
        check_vals("R1", '0, '0);

        // R4/R5: start code 011, code 0 => step every tick
        wr(8'h02, 8'h00);
        wr(8'h03, 8'h60);
        wr(8'h01, 8'h01);
        check_frame("R4", 3);
        exp_f = 3;
        for (int k = 0; k < 6; k++) begin
            btick();
            exp_f = (exp_f + 1) % 8;
            check_frame("R5", exp_f);
        end

        // R3: code 2 => four ticks per step
        wr(8'h02, 8'h40);
        wr(8'h01, 8'h00);
        wr(8'h01, 8'h01);
        check_frame("R4", 3);
        for (int k = 1; k <= 3; k++) begin
            btick();
            check_frame("R3", 3);
        end
        btick();
        check_frame("R3", 4);
        // R4: repeated 01 write mid-count does not restart count
        btick(); btick();
        wr(8'h01, 8'h01);
        check_frame("R4", 4);
        btick();
        check_frame("R4", 4);
        btick();
        check_frame("R4", 5);

        // R3: longest code 7 => 128 ticks; start frame 8 wraps to 1
        wr(8'h02, 8'hE0);
        wr(8'h03, 8'hE0);
        wr(8'h01, 8'h00);
        wr(8'h01, 8'h01);
        check_frame("R4", 7);
        repeat (127) btick();
        check_frame("R3", 7);
        btick();
        check_frame("R5", 0);

        // R2: direct and reserved modes hold outputs
        wr(8'h02, 8'h00);
        wr(8'h01, 8'h00);
        level = 8'hFF;
        wr(8'h04, 8'h01);
        btick(); rtick(); btick();
        check_frame("R2", 0);
        wr(8'h01, 8'h03);
        btick(); rtick(); level = 8'h80; rtick();
        check_frame("R2", 0);

        // R6: level-follow, directed extremes
        wr(8'h01, 8'h02);
        level = 8'hFF;
        rtick();
        check_frame("R6", 7);
        level = 8'h00;
        rtick();
        check_frame("R6", 0);
        exp_f = 0;

        // R6: random magnitudes and divider values
        for (int it = 0; it < 24; it++) begin
            int r;
            r = 1 + int'($urandom_range(0, 4));
            wr(8'h04, 8'(r));
            level = 8'($urandom);
            for (int k = 1; k <= r; k++) begin
                rtick();
                if (k == r) exp_f = int'(level[7:5]);
                check_frame("R6", exp_f);
            end
        end

        // R7: zero divider holds frame
        wr(8'h04, 8'h00);
        level = {3'(exp_f + 3), 5'h11};
        repeat (5) rtick();
        check_frame("R7", exp_f);

        // R9: rewrite shown record, output stays stale
        held_l = led_en;
        held_d = duty;
        old_b  = mem_m[exp_f*18 + 2];
        mem_m[exp_f*18 + 2] = ~old_b;
        wr(8'(8'h20 + exp_f*18 + 2), ~old_b);
        wr(8'h04, 8'h01);
        level = {3'(exp_f), 5'h00};
        rtick();
        check_vals("R9", held_l, held_d);
        level = {3'(exp_f + 1), 5'h00};
        rtick();
        check_frame("R9", (exp_f + 1) % 8);
        level = {3'(exp_f), 5'h00};
        rtick();
        check_frame("R9", exp_f);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule